// File: doc/BRIEF.md
# Watchdog Timeout Normalizer

This block turns a requested watchdog timeout into the two settings a watchdog timer needs: a prescaler code and a 16-bit compare value. The caller presents a tick rate in hertz and a timeout in whole seconds and pulses `start_i`. The block first forces the timeout into the range 1 to 2048 seconds, then multiplies it by the tick rate to get a raw tick count.

It then divides that count by four once per clock cycle, raising the prescaler code by one at each step. It stops when the count fits in 16 bits, or when the largest prescaler has been reached. Prescaler code `k` means the watchdog clock is divided by 4^k, for k from 0 to 5. If the count is still too large at code 5, the compare value saturates at 0xFFFF.

When the result is ready, `done_o` pulses for one cycle. The prescaler code and compare value stay on the outputs until the next result is ready. A request made while a computation is running is ignored.

The controller has two states. In `ST_IDLE` a start request loads the product and takes the **accept** transition to `ST_NORM`. In `ST_NORM` the **step** transition loops on `ST_NORM` while the count is above 0xFFFF and the code is below its maximum. The **finish** transition returns to `ST_IDLE` when the count fits. The **saturate** transition returns to `ST_IDLE` when the code is already at its maximum and the count is still too large. Both finish and saturate update the outputs and raise `done_o` in the following cycle.

Top module: `wdt_timeout_normalizer`

## Requirements
- R1: After reset `done_o` is 0, `psc_code_o` is 0, `cmp_val_o` is 0 and the controller is idle.
- R2: A start accepted while idle loads a raw count equal to `rate_hz_i` times the clamped timeout, held without overflow in 48 bits.
- R3: A timeout of 0 is treated as 1 second, and a timeout above 2048 is treated as 2048 seconds; values from 1 to 2048 are used unchanged.
- R4: Each normalizing cycle in which the count exceeds 0xFFFF and the code is below 5 shifts the count right by two bits and adds one to the code. The code starts at 0 (divide by 1) and never exceeds 5 (divide by 1024).
- R5: When the count is at most 0xFFFF, `cmp_val_o` becomes the count and `psc_code_o` becomes the number of steps taken. `done_o` is high exactly N+1 cycles after the accepting clock edge, where N is the number of steps.
- R6: If the count still exceeds 0xFFFF when the code is 5, `cmp_val_o` becomes 0xFFFF and `psc_code_o` becomes 5, and `done_o` rises in the next cycle.
- R7: `done_o` is high for a single cycle per result. `psc_code_o` and `cmp_val_o` hold their values until the next result.
- R8: A start request while a computation is in progress is ignored: it neither changes the result nor produces an extra `done_o`.
- R9: A start request in the cycle where `done_o` is high is accepted, so back-to-back computations lose no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new computation (taken only while idle) |
| rate_hz_i | input | 32 | Tick rate of the watchdog clock in hertz |
| timeout_s_i | input | 16 | Requested timeout in seconds |
| done_o | output | 1 | One-cycle pulse when a new result is on the outputs |
| psc_code_o | output | 3 | Prescaler code k, divide by 4^k |
| cmp_val_o | output | 16 | Compare value for the watchdog counter |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. The bench holds `start_i` high across a whole computation and swaps the operands in the cycle `done_o` is seen. The behavioural model, stepped on every clock, then expects the second job to begin at that very edge and to complete with its own result. A second collision, a request arriving in the middle of a computation, is judged by requiring that the first result stands and that no extra completion pulse appears.

// File: rtl/tnorm_pkg.sv
package tnorm_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_NORM = 1'b1
    } tnorm_state_e;

endpackage

// File: rtl/tnorm_clamp.sv
// Forces the requested timeout into the legal window.
module tnorm_clamp #(
    parameter int SECS_W   = 16,
    parameter int SECS_MIN = 1,
    parameter int SECS_MAX = 2048
) (
    input  logic [SECS_W-1:0] secs_i,
    output logic [SECS_W-1:0] secs_o
);
    localparam logic [SECS_W-1:0] LO = SECS_W'(SECS_MIN);
    localparam logic [SECS_W-1:0] HI = SECS_W'(SECS_MAX);

    always_comb begin
        if (secs_i < LO) begin
            secs_o = LO;
        end else if (secs_i > HI) begin
            secs_o = HI;
        end else begin
            secs_o = secs_i;
        end
    end
endmodule

// File: rtl/tnorm_step.sv
// One base-4 normalizing step: range test and next values.
module tnorm_step #(
    parameter int PROD_W  = 48,
    parameter int CMP_W   = 16,
    parameter int PSC_W   = 3,
    parameter int PSC_MAX = 5
) (
    input  logic [PROD_W-1:0] count_i,
    input  logic [PSC_W-1:0]  code_i,
    output logic              over_o,
    output logic              at_top_o,
    output logic [PROD_W-1:0] count_nxt_o,
    output logic [PSC_W-1:0]  code_nxt_o
);
    localparam logic [PROD_W-1:0] LIMIT =
        {{(PROD_W-CMP_W){1'b0}}, {CMP_W{1'b1}}};

    always_comb begin
        over_o      = (count_i > LIMIT);
        at_top_o    = (code_i == PSC_W'(PSC_MAX));
        count_nxt_o = count_i >> 2;
        code_nxt_o  = code_i + 1'b1;
    end
endmodule

// File: rtl/tnorm_ctrl.sv
// State machine, working registers and result registers.
module tnorm_ctrl
    import tnorm_pkg::*;
#(
    parameter int PROD_W  = 48,
    parameter int CMP_W   = 16,
    parameter int PSC_W   = 3,
    parameter int PSC_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PROD_W-1:0] load_i,
    input  logic              over_i,
    input  logic              at_top_i,
    input  logic [PROD_W-1:0] count_nxt_i,
    input  logic [PSC_W-1:0]  code_nxt_i,
    output logic [PROD_W-1:0] count_o,
    output logic [PSC_W-1:0]  code_o,
    output logic              done_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic [CMP_W-1:0]  cmp_o
);
    tnorm_state_e      state_q, state_d;
    logic [PROD_W-1:0] count_q;
    logic [PSC_W-1:0]  code_q;
    logic              done_q;
    logic [PSC_W-1:0]  psc_q;
    logic [CMP_W-1:0]  cmp_q;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_NORM;                 // accept
            ST_NORM: if (!over_i || at_top_i) state_d = ST_IDLE;     // finish / saturate
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            code_q  <= '0;
            done_q  <= 1'b0;
            psc_q   <= '0;
            cmp_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        count_q <= load_i;
                        code_q  <= '0;
                    end
                end
                ST_NORM: begin
                    if (over_i && !at_top_i) begin
                        count_q <= count_nxt_i;
                        code_q  <= code_nxt_i;
                    end else begin
                        done_q <= 1'b1;
                        psc_q  <= code_q;
                        cmp_q  <= over_i ? {CMP_W{1'b1}} : count_q[CMP_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    assign count_o = count_q;
    assign code_o  = code_q;
    assign done_o  = done_q;
    assign psc_o   = psc_q;
    assign cmp_o   = cmp_q;

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4: a step quarters the count and bumps the code
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && over_i && !at_top_i) |=>
        (count_q == ($past(count_q) >> 2)) && (code_q == $past(code_q) + 1'b1));

    // R4: code stays within the prescaler range
    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= PSC_W'(PSC_MAX));

    // R5: a fitting count is published unchanged
    p_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && !over_i) |=>
        done_q && (cmp_q == $past(count_q[CMP_W-1:0])) && (psc_q == $past(code_q)));

    // R6: exhausted prescaler saturates the compare value
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && over_i && at_top_i) |=>
        done_q && (cmp_q == {CMP_W{1'b1}}) && (psc_q == PSC_W'(PSC_MAX)));

    // R8: a request during a computation does not restart it
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && start_i && over_i && !at_top_i) |=>
        (state_q == ST_NORM) && (code_q != '0));
endmodule

// File: rtl/wdt_timeout_normalizer.sv
module wdt_timeout_normalizer #(
    parameter int RATE_W   = 32,
    parameter int SECS_W   = 16,
    parameter int CMP_W    = 16,
    parameter int PSC_W    = 3,
    parameter int PSC_MAX  = 5,
    parameter int SECS_MIN = 1,
    parameter int SECS_MAX = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_hz_i,
    input  logic [SECS_W-1:0] timeout_s_i,
    output logic              done_o,
    output logic [PSC_W-1:0]  psc_code_o,
    output logic [CMP_W-1:0]  cmp_val_o
);
    localparam int PROD_W = RATE_W + SECS_W;

    logic [SECS_W-1:0] secs_c;
    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] count_q, count_nxt;
    logic [PSC_W-1:0]  code_q, code_nxt;
    logic              over, at_top;

    tnorm_clamp #(
        .SECS_W(SECS_W), .SECS_MIN(SECS_MIN), .SECS_MAX(SECS_MAX)
    ) u_clamp (
        .secs_i(timeout_s_i),
        .secs_o(secs_c)
    );

    assign product = PROD_W'(rate_hz_i) * PROD_W'(secs_c);

    tnorm_step #(
        .PROD_W(PROD_W), .CMP_W(CMP_W), .PSC_W(PSC_W), .PSC_MAX(PSC_MAX)
    ) u_step (
        .count_i    (count_q),
        .code_i     (code_q),
        .over_o     (over),
        .at_top_o   (at_top),
        .count_nxt_o(count_nxt),
        .code_nxt_o (code_nxt)
    );

    tnorm_ctrl #(
        .PROD_W(PROD_W), .CMP_W(CMP_W), .PSC_W(PSC_W), .PSC_MAX(PSC_MAX)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .load_i     (product),
        .over_i     (over),
        .at_top_i   (at_top),
        .count_nxt_i(count_nxt),
        .code_nxt_i (code_nxt),
        .count_o    (count_q),
        .code_o     (code_q),
        .done_o     (done_o),
        .psc_o      (psc_code_o),
        .cmp_o      (cmp_val_o)
    );

    // R3: the clamped timeout never leaves the legal window
    p_clamp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (secs_c >= SECS_W'(SECS_MIN)) && (secs_c <= SECS_W'(SECS_MAX)));
endmodule

// File: tb/wdt_timeout_normalizer_bench.sv
module wdt_timeout_normalizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] rate = '0;
    logic [15:0] secs = '0;
    logic        done_o;
    logic [2:0]  psc_o;
    logic [15:0] cmp_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdt_timeout_normalizer u_wdt_timeout_normalizer (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rate_hz_i(rate), .timeout_s_i(secs),
        .done_o(done_o), .psc_code_o(psc_o), .cmp_val_o(cmp_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: result and number of quartering steps
    function automatic void calc(input longint r, input longint s,
                                 output int code, output int cmp, output int steps);
        longint t;
        longint sc;
        sc = (s < 1) ? 1 : ((s > 2048) ? 2048 : s);
        t = r * sc;
        code = 0;
        steps = 0;
        while (t > 65535) begin
            if (code == 5) begin
                t = 65535;
                break;
            end
            t = t / 4;
            code++;
            steps++;
        end
        cmp = int'(t);
    endfunction

    // Cycle model, advanced and compared at every falling edge
    bit m_busy = 0;
    int m_rem = 0;
    int p_code = 0, p_cmp = 0;
    int m_code = 0, m_cmp = 0;
    bit m_done = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rem = 0; m_code = 0; m_cmp = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_rem == 0) begin
                    m_busy = 0; m_code = p_code; m_cmp = p_cmp; m_done = 1;
                end else begin
                    m_rem--;
                end
            end else if (start) begin
                calc(rate, secs, p_code, p_cmp, m_rem);
                m_busy = 1;
            end
            chk("R7 model done", done_o, m_done);
            chk("R4 model code", psc_o, m_code);
            chk("R5 model compare", cmp_o, m_cmp);
        end
    end

    // Issue one job and wait for completion; returns cycles to done
    task automatic run(input logic [31:0] r, input logic [15:0] s, output int lat);
        @(negedge clk); #1;
        start = 1'b1; rate = r; secs = s;
        @(negedge clk); #1;
        start = 1'b0;
        lat = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done_o) begin
                lat = i + 1;
                break;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        chk("R1 reset done", done_o, 0);
        chk("R1 reset code", psc_o, 0);
        chk("R1 reset compare", cmp_o, 0);
        #1 rst_n = 1'b1;

        // R2: plain product, no step
        run(32'd1000, 16'd60, lat);
        chk("R2 compare", cmp_o, 60000);
        chk("R2 code", psc_o, 0);
        chk("R5 latency zero steps", lat, 1);

        // one step at the usual 5 s timeout
        run(32'd32768, 16'd5, lat);
        chk("R4 code one step", psc_o, 1);
        chk("R4 compare one step", cmp_o, 16'hA000);
        chk("R5 latency one step", lat, 2);

        // R3: clamping at both ends
        run(32'd1000, 16'd0, lat);
        chk("R3 zero timeout compare", cmp_o, 1000);
        chk("R3 zero timeout code", psc_o, 0);
        run(32'd100, 16'd5000, lat);
        chk("R3 high timeout compare", cmp_o, 16'hC800);
        chk("R3 high timeout code", psc_o, 1);

        // R5: 16-bit boundary
        run(32'd65535, 16'd1, lat);
        chk("R5 boundary fits compare", cmp_o, 16'hFFFF);
        chk("R5 boundary fits code", psc_o, 0);
        run(32'd65536, 16'd1, lat);
        chk("R5 boundary over compare", cmp_o, 16'h4000);
        chk("R5 boundary over code", psc_o, 1);
        run(32'd0, 16'd9, lat);
        chk("R5 zero rate compare", cmp_o, 0);

        // R6: saturation, exactly 2^16 left at top code
        run(32'd32768, 16'd2048, lat);
        chk("R6 saturate compare", cmp_o, 16'hFFFF);
        chk("R6 saturate code", psc_o, 5);
        chk("R6 latency", lat, 6);
        run(32'hFFFF_FFFF, 16'd2048, lat);
        chk("R6 max operands compare", cmp_o, 16'hFFFF);
        chk("R6 max operands code", psc_o, 5);

        // R7: results hold after the pulse
        repeat (4) @(negedge clk);
        chk("R7 done low after pulse", done_o, 0);
        chk("R7 compare held", cmp_o, 16'hFFFF);

        // R8: request mid-computation ignored
        @(negedge clk); #1;
        start = 1'b1; rate = 32'd32768; secs = 16'd2048;
        @(negedge clk); #1;
        start = 1'b0;
        @(negedge clk); #1;
        start = 1'b1; rate = 32'd1; secs = 16'd1;
        @(negedge clk); #1;
        start = 1'b0;
        lat = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done_o) begin
                lat = i;
                break;
            end
        end
        chk("R8 first result kept compare", cmp_o, 16'hFFFF);
        chk("R8 first result kept code", psc_o, 5);
        repeat (3) @(negedge clk);
        chk("R8 no extra done", done_o, 0);

        // R9: start held through done, second job in done cycle
        @(negedge clk); #1;
        start = 1'b1; rate = 32'd1000; secs = 16'd60;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done_o) break;
        end
        chk("R9 first job compare", cmp_o, 60000);
        #1 rate = 32'd65536; secs = 16'd1;
        @(negedge clk); #1;
        start = 1'b0;
        lat = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done_o) begin
                lat = i + 1;
                break;
            end
        end
        chk("R9 back to back latency", lat, 2);
        chk("R9 second job compare", cmp_o, 16'h4000);
        chk("R9 second job code", psc_o, 1);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule